// File: doc/BRIEF.md
# Masked Packed Float-to-Unsigned Converter

This block converts a vector of 32-bit single-precision floating-point elements into 32-bit unsigned integers, one element per lane. A two-bit length code selects 4, 8 or 16 active lanes, which is a 128, 256 or 512-bit vector. Lane j always occupies bits [32j+31:32j]. A per-lane write mask, an enable for that mask and a zeroing/merging select decide what each lane of the destination receives. A broadcast control can replicate the lowest source element into every lane when the source is memory-style. When the source is a register at the full 512-bit length, the same control instead replaces the global rounding mode with an embedded one. The destination is always cleared above the active length.

The work is sequenced by a small state machine. It handles one group of four lanes per clock. Its states are IDLE, RUN, DONE and FAULT, and it has these transitions:
- IDLE to RUN on `start` with a legal request. The operands are captured and the destination is cleared.
- IDLE to FAULT on `start` with an illegal request.
- RUN to RUN while lane groups remain.
- RUN to DONE after the last group is written.
- DONE to IDLE and FAULT to IDLE unconditionally.

`done` is high for one cycle in DONE or FAULT. `undef_op` is also high in FAULT.

Top module: `pk_cvt_lane_ctrl`

## Requirements
- R1: Length code 0, 1 and 2 select 4, 8 and 16 active lanes (128, 256 and 512 bits), and lane j is bits [32j+31:32j] of source and destination.
- R2: A written lane holds the source element rounded to an integer by the selected mode, with rounding code 00 = nearest-even, 01 = toward minus infinity, 10 = toward plus infinity and 11 = toward zero. The inexact flag is set when rounding discarded a nonzero fraction.
- R3: NaN, infinity, a value that rounds to 2^32 or above, and a negative value that rounds to a nonzero integer all give 0xFFFFFFFF with the invalid flag set and no inexact contribution from that lane.
- R4: The embedded rounding code `rm_emb` is used only when the length code is 2, `bcst_ovr` is 1 and `src_is_mem` is 0. In every other case `rm_glob` is used.
- R5: When `src_is_mem` and `bcst_ovr` are both 1, every active lane converts source bits [31:0].
- R6: An active lane is written with its converted value when its `wmask` bit is 1 or `mask_en` is 0.
- R7: An active lane that is masked off keeps the matching `old_dst` lane when `zero_mode` is 0, and becomes 0 when `zero_mode` is 1.
- R8: Every destination bit from the active length up to bit 511 is 0 after a legal operation.
- R9: `flag_inv` and `flag_inx` are the OR of the per-lane flags over written lanes only. A masked-off lane contributes nothing.
- R10: If `spec_field` is not 4'b1111, or the length code is 3, the request goes to FAULT. `done` and `undef_op` are high for one cycle, one cycle after the start edge, and `dst_vec` and both flags keep their previous values.
- R11: After reset, `dst_vec`, the flags, `done` and `undef_op` are 0. A legal request shows `done` (with `undef_op` low) N/4+1 cycles after the start edge, where N is the lane count, and `done` lasts one cycle. `start` is ignored outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request, sampled in IDLE |
| vl_code | input | 2 | Length code: 0=128, 1=256, 2=512, 3=illegal |
| spec_field | input | 4 | Reserved specifier; must be 4'b1111 |
| src_vec | input | 512 | Source elements |
| src_is_mem | input | 1 | Source is memory-style (1) or a register (0) |
| bcst_ovr | input | 1 | Broadcast for memory source, rounding override for register source |
| wmask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | 1 = apply `wmask` |
| zero_mode | input | 1 | 1 = zero masked lanes, 0 = merge |
| old_dst | input | 512 | Previous destination for merging |
| rm_glob | input | 2 | Global rounding code |
| rm_emb | input | 2 | Embedded rounding code |
| done | output | 1 | One-cycle completion pulse |
| undef_op | output | 1 | Illegal request, with `done` |
| dst_vec | output | 512 | Destination vector |
| flag_inv | output | 1 | OR of invalid over written lanes |
| flag_inx | output | 1 | OR of inexact over written lanes |

## Verification
The assertions check the following on every cycle:
- `done` is a single-cycle pulse.
- `undef_op` never appears without `done`.
- A fault leaves the destination and flags untouched.
- The lane-group counter stays within the active length.
- A 128-bit result has zero upper bits.
- A lane reported invalid carries the saturated value.

The actual converted values, the choice between embedded and global rounding, broadcast, merge and zero masking, flag masking and the completion latency are shown only by the bench. It compares every result against a real-arithmetic model under directed and pseudo-random requests.

// File: rtl/pk_cvt_pkg.sv
package pk_cvt_pkg;

    localparam int FP_W = 32;
    localparam logic [3:0] SPEC_OK = 4'b1111;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_t;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_BAD = 2'd3
    } vlen_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_DONE  = 2'd2,
        S_FAULT = 2'd3
    } cvt_state_t;

endpackage

// File: rtl/pk_cvt_f2u.sv
module pk_cvt_f2u
    import pk_cvt_pkg::*;
(
    input  logic [FP_W-1:0] fp_in,
    input  rmode_t          rm,
    output logic [FP_W-1:0] int_out,
    output logic            inv,
    output logic            inx
);

    localparam int SIG_W = 24;
    localparam logic [7:0] BIAS_INT = 8'd150;   // exponent at which the significand is an integer
    localparam logic [7:0] MAX_LSH  = 8'd8;     // 24-bit significand shifted by 8 still fits in 32 bits

    logic             sgn;
    logic [7:0]       ex;
    logic [7:0]       eff;
    logic [SIG_W-1:0] sig;
    logic [7:0]       lsh;
    logic [7:0]       rsh;
    logic [2*SIG_W-1:0] ext;
    logic [SIG_W-1:0] whole;
    logic             rbit;
    logic             sbit;
    logic             lost;
    logic             up;
    logic [FP_W-1:0]  mag;

    always_comb begin
        sgn   = fp_in[31];
        ex    = fp_in[30:23];
        sig   = {(ex != 8'd0), fp_in[22:0]};
        eff   = (ex == 8'd0) ? 8'd1 : ex;
        lsh   = 8'd0;
        rsh   = 8'd0;
        ext   = '0;
        whole = '0;
        rbit  = 1'b0;
        sbit  = 1'b0;
        lost  = 1'b0;
        up    = 1'b0;
        mag   = '0;
        inv   = 1'b0;
        if (ex == 8'hFF) begin
            inv = 1'b1;
        end else if (eff >= BIAS_INT) begin
            lsh = eff - BIAS_INT;
            if (lsh > MAX_LSH) inv = 1'b1;
            else               mag = {8'd0, sig} << lsh;
        end else begin
            rsh = BIAS_INT - eff;
            if (rsh > 8'd24) begin
                sbit = |sig;
            end else begin
                ext   = {sig, 24'd0} >> rsh;
                whole = ext[47:24];
                rbit  = ext[23];
                sbit  = |ext[22:0];
            end
            lost = rbit | sbit;
            case (rm)
                RM_NEAR: up = rbit & (sbit | whole[0]);
                RM_DOWN: up = sgn & lost;
                RM_UP:   up = ~sgn & lost;
                default: up = 1'b0;
            endcase
            mag = {8'd0, whole} + {31'd0, up};
        end
        if (!inv && sgn && (mag != '0)) inv = 1'b1;
        int_out = inv ? '1 : (sgn ? '0 : mag);
        inx     = ~inv & lost;
    end

    always_comb begin
        if (inv) begin
            a_r3_sat_value: assert (int_out == 32'hFFFF_FFFF && !inx)
                else $error("R3: invalid lane not saturated");
        end
    end

endmodule

// File: rtl/pk_cvt_decode.sv
module pk_cvt_decode
    import pk_cvt_pkg::*;
#(
    parameter int MAX_LANES = 16,
    parameter int GRP_LANES = 4,
    localparam int LC_W     = $clog2(MAX_LANES + 1),
    localparam int NUM_BEATS = (MAX_LANES + GRP_LANES - 1) / GRP_LANES,
    localparam int BEAT_W   = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
)(
    input  vlen_t             vl,
    input  logic [3:0]        spec_field,
    input  logic              bcst_ovr,
    input  logic              src_is_mem,
    input  rmode_t            rm_glob,
    input  rmode_t            rm_emb,
    output logic              bad,
    output rmode_t            rm_sel,
    output logic [LC_W-1:0]   lanes,
    output logic [BEAT_W-1:0] last_beat
);

    int nbeat;

    always_comb begin
        unique case (vl)
            VL_128:  lanes = LC_W'(4);
            VL_256:  lanes = LC_W'(8);
            VL_512:  lanes = LC_W'(16);
            default: lanes = '0;
        endcase
        bad    = (spec_field != SPEC_OK) || (vl == VL_BAD) || (int'(lanes) > MAX_LANES);
        rm_sel = (vl == VL_512 && bcst_ovr && !src_is_mem) ? rm_emb : rm_glob;
        nbeat  = (int'(lanes) + GRP_LANES - 1) / GRP_LANES;
        last_beat = BEAT_W'(nbeat - 1);
    end

endmodule

// File: rtl/pk_cvt_group.sv
module pk_cvt_group
    import pk_cvt_pkg::*;
#(
    parameter int GRP_LANES = 4,
    localparam int GRP_W    = GRP_LANES * FP_W
)(
    input  logic [GRP_W-1:0]     src_g,
    input  logic [GRP_W-1:0]     old_g,
    input  logic [GRP_LANES-1:0] wmask_g,
    input  logic [GRP_LANES-1:0] act_g,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    input  rmode_t               rm,
    output logic [GRP_W-1:0]     dst_g,
    output logic                 inv_g,
    output logic                 inx_g
);

    logic [GRP_LANES-1:0] inv_v;
    logic [GRP_LANES-1:0] inx_v;

    for (genvar k = 0; k < GRP_LANES; k++) begin : g_lane
        logic [FP_W-1:0] conv;
        logic            c_inv;
        logic            c_inx;
        logic            wr;

        pk_cvt_f2u u_f2u (
            .fp_in  (src_g[k*FP_W +: FP_W]),
            .rm     (rm),
            .int_out(conv),
            .inv    (c_inv),
            .inx    (c_inx)
        );

        always_comb begin
            wr = act_g[k] & (wmask_g[k] | ~mask_en);
            if (wr)
                dst_g[k*FP_W +: FP_W] = conv;
            else if (act_g[k] && !zero_mode)
                dst_g[k*FP_W +: FP_W] = old_g[k*FP_W +: FP_W];
            else
                dst_g[k*FP_W +: FP_W] = '0;
            inv_v[k] = wr & c_inv;
            inx_v[k] = wr & c_inx;
        end
    end

    assign inv_g = |inv_v;
    assign inx_g = |inx_v;

endmodule

// File: rtl/pk_cvt_lane_ctrl.sv
module pk_cvt_lane_ctrl
    import pk_cvt_pkg::*;
#(
    parameter int MAX_LANES = 16,
    parameter int GRP_LANES = 4
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [1:0]                vl_code,
    input  logic [3:0]                spec_field,
    input  logic [MAX_LANES*32-1:0]   src_vec,
    input  logic                      src_is_mem,
    input  logic                      bcst_ovr,
    input  logic [MAX_LANES-1:0]      wmask,
    input  logic                      mask_en,
    input  logic                      zero_mode,
    input  logic [MAX_LANES*32-1:0]   old_dst,
    input  logic [1:0]                rm_glob,
    input  logic [1:0]                rm_emb,
    output logic                      done,
    output logic                      undef_op,
    output logic [MAX_LANES*32-1:0]   dst_vec,
    output logic                      flag_inv,
    output logic                      flag_inx
);

    localparam int VEC_W     = MAX_LANES * FP_W;
    localparam int GRP_W     = GRP_LANES * FP_W;
    localparam int LC_W      = $clog2(MAX_LANES + 1);
    localparam int NUM_BEATS = (MAX_LANES + GRP_LANES - 1) / GRP_LANES;
    localparam int BEAT_W    = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1;
    localparam int LOW_W     = 4 * FP_W;

    cvt_state_t state_q, state_d;

    logic              dec_bad;
    rmode_t            dec_rm;
    logic [LC_W-1:0]   dec_lanes;
    logic [BEAT_W-1:0] dec_last;

    logic [VEC_W-1:0]     src_q;
    logic [VEC_W-1:0]     old_q;
    logic [MAX_LANES-1:0] mask_q;
    logic                 men_q;
    logic                 zero_q;
    rmode_t               rm_q;
    vlen_t                vl_q;
    logic [LC_W-1:0]      lanes_q;
    logic [BEAT_W-1:0]    last_q;
    logic [BEAT_W-1:0]    beat_q;
    logic [VEC_W-1:0]     dst_q;
    logic                 inv_q;
    logic                 inx_q;

    logic [GRP_LANES-1:0] act_g;
    logic [GRP_W-1:0]     grp_dst;
    logic                 grp_inv;
    logic                 grp_inx;

    pk_cvt_decode #(
        .MAX_LANES(MAX_LANES),
        .GRP_LANES(GRP_LANES)
    ) u_decode (
        .vl        (vlen_t'(vl_code)),
        .spec_field(spec_field),
        .bcst_ovr  (bcst_ovr),
        .src_is_mem(src_is_mem),
        .rm_glob   (rmode_t'(rm_glob)),
        .rm_emb    (rmode_t'(rm_emb)),
        .bad       (dec_bad),
        .rm_sel    (dec_rm),
        .lanes     (dec_lanes),
        .last_beat (dec_last)
    );

    always_comb begin
        for (int k = 0; k < GRP_LANES; k++)
            act_g[k] = (int'(beat_q) * GRP_LANES + k) < int'(lanes_q);
    end

    pk_cvt_group #(
        .GRP_LANES(GRP_LANES)
    ) u_group (
        .src_g    (src_q[beat_q*GRP_W +: GRP_W]),
        .old_g    (old_q[beat_q*GRP_W +: GRP_W]),
        .wmask_g  (mask_q[beat_q*GRP_LANES +: GRP_LANES]),
        .act_g    (act_g),
        .mask_en  (men_q),
        .zero_mode(zero_q),
        .rm       (rm_q),
        .dst_g    (grp_dst),
        .inv_g    (grp_inv),
        .inx_g    (grp_inx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = dec_bad ? S_FAULT : S_RUN;
            S_RUN:   if (beat_q == last_q) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and lane-group datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            old_q   <= '0;
            mask_q  <= '0;
            men_q   <= 1'b0;
            zero_q  <= 1'b0;
            rm_q    <= RM_NEAR;
            vl_q    <= VL_128;
            lanes_q <= '0;
            last_q  <= '0;
            beat_q  <= '0;
            dst_q   <= '0;
            inv_q   <= 1'b0;
            inx_q   <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start && !dec_bad) begin
                src_q   <= (bcst_ovr && src_is_mem) ? {MAX_LANES{src_vec[FP_W-1:0]}} : src_vec;
                old_q   <= old_dst;
                mask_q  <= wmask;
                men_q   <= mask_en;
                zero_q  <= zero_mode;
                rm_q    <= dec_rm;
                vl_q    <= vlen_t'(vl_code);
                lanes_q <= dec_lanes;
                last_q  <= dec_last;
                beat_q  <= '0;
                dst_q   <= '0;
                inv_q   <= 1'b0;
                inx_q   <= 1'b0;
            end else if (state_q == S_RUN) begin
                dst_q[beat_q*GRP_W +: GRP_W] <= grp_dst;
                inv_q  <= inv_q | grp_inv;
                inx_q  <= inx_q | grp_inx;
                beat_q <= beat_q + BEAT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        done     = 1'b0;
        undef_op = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_RUN:   ;
            S_DONE:  done = 1'b1;
            S_FAULT: begin
                done     = 1'b1;
                undef_op = 1'b1;
            end
        endcase
    end

    assign dst_vec  = dst_q;
    assign flag_inv = inv_q;
    assign flag_inx = inx_q;

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("R11: done longer than one cycle");

    a_r10_ud_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        undef_op |-> done) else $error("R10: undef_op without done");

    a_r10_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        undef_op |-> ($stable(dst_vec) && $stable(flag_inv) && $stable(flag_inx)))
        else $error("R10: fault changed result");

    a_r11_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (beat_q <= last_q)) else $error("R11: beat past end");

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !undef_op && vl_q == VL_128) |-> (dst_vec[VEC_W-1:LOW_W] == '0))
        else $error("R8: upper bits not cleared");

endmodule

// File: tb/tb_pk_cvt_lane_ctrl.sv
module tb_pk_cvt_lane_ctrl;

    typedef struct packed {
        logic [511:0] dst;
        logic         inv;
        logic         inx;
        logic         ud;
        logic [7:0]   lat;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   vl_code = 2'd0;
    logic [3:0]   spec_field = 4'hF;
    logic [511:0] src_vec = '0;
    logic         src_is_mem = 1'b0;
    logic         bcst_ovr = 1'b0;
    logic [15:0]  wmask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic [511:0] old_dst = '0;
    logic [1:0]   rm_glob = 2'b00;
    logic [1:0]   rm_emb = 2'b00;
    logic         done, undef_op, flag_inv, flag_inx;
    logic [511:0] dst_vec;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int t_start = 0;
    exp_t  q[$];
    string tq[$];
    logic [511:0] last_dst = '0;
    logic last_inv = 1'b0, last_inx = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    pk_cvt_lane_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_code(vl_code),
        .spec_field(spec_field), .src_vec(src_vec), .src_is_mem(src_is_mem),
        .bcst_ovr(bcst_ovr), .wmask(wmask), .mask_en(mask_en),
        .zero_mode(zero_mode), .old_dst(old_dst), .rm_glob(rm_glob),
        .rm_emb(rm_emb), .done(done), .undef_op(undef_op), .dst_vec(dst_vec),
        .flag_inv(flag_inv), .flag_inx(flag_inx)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Real-arithmetic reference for one element
    task automatic ref_cvt(input logic [31:0] f, input logic [1:0] rm,
                           output logic [31:0] r, output logic inv, output logic inx);
        int  e;
        real v, fl, fr, rr;
        longint lv;
        e = int'(f[30:23]);
        inv = 1'b0; inx = 1'b0; r = '0;
        if (e == 255) begin
            inv = 1'b1; r = '1;
            return;
        end
        if (e == 0) begin
            v = real'(f[22:0]);
            e = 1;
        end else begin
            v = real'({1'b1, f[22:0]});
        end
        if (e > 150) for (int i = 0; i < e - 150; i++) v = v * 2.0;
        else         for (int i = 0; i < 150 - e; i++) v = v / 2.0;
        if (f[31]) v = -v;
        fl = $floor(v);
        fr = v - fl;
        case (rm)
            2'b00:   rr = (fr > 0.5 || (fr == 0.5 && $floor(fl / 2.0) * 2.0 != fl)) ? fl + 1.0 : fl;
            2'b01:   rr = fl;
            2'b10:   rr = (fr > 0.0) ? fl + 1.0 : fl;
            default: rr = (v < 0.0) ? -$floor(-v) : fl;
        endcase
        if (rr < 0.0 || rr > 4294967295.0) begin
            inv = 1'b1; r = '1;
        end else begin
            lv = longint'(rr);
            r = lv[31:0];
            inx = (fr != 0.0);
        end
    endtask

    task automatic model(output exp_t e);
        int nl;
        logic [1:0] rm;
        logic [31:0] el, r;
        logic li, lx;
        if (spec_field != 4'hF || vl_code == 2'd3) begin
            e.dst = last_dst; e.inv = last_inv; e.inx = last_inx;
            e.ud = 1'b1; e.lat = 8'd1;
            return;
        end
        nl = 4 << vl_code;
        rm = (vl_code == 2'd2 && bcst_ovr && !src_is_mem) ? rm_emb : rm_glob;
        e.dst = '0; e.inv = 1'b0; e.inx = 1'b0; e.ud = 1'b0;
        e.lat = 8'(nl / 4 + 1);
        for (int j = 0; j < nl; j++) begin
            el = (bcst_ovr && src_is_mem) ? src_vec[31:0] : src_vec[32*j +: 32];
            if (!mask_en || wmask[j]) begin
                ref_cvt(el, rm, r, li, lx);
                e.dst[32*j +: 32] = r;
                e.inv |= li;
                e.inx |= lx;
            end else if (!zero_mode) begin
                e.dst[32*j +: 32] = old_dst[32*j +: 32];
            end
        end
        last_dst = e.dst; last_inv = e.inv; last_inx = e.inx;
    endtask

    // Driver: operands are already set; push expectation, pulse start, wait for done
    task automatic run_op(input string tag);
        exp_t e;
        model(e);
        q.push_back(e);
        tq.push_back(tag);
        start = 1'b1;
        t_start = cyc;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_op(input logic [1:0] vl, input logic mem, input logic bc,
                          input logic [15:0] mk, input logic men, input logic zr,
                          input logic [1:0] rg, input logic [1:0] re);
        vl_code = vl; src_is_mem = mem; bcst_ovr = bc; wmask = mk;
        mask_en = men; zero_mode = zr; rm_glob = rg; rm_emb = re; spec_field = 4'hF;
    endtask

    function automatic logic [31:0] rnd32();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Monitor: pop and compare on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 512'(done), 512'(0));
            end else begin
                exp_t e;
                string tg;
                e = q.pop_front();
                tg = tq.pop_front();
                check(dst_vec == e.dst, tg, "dst", dst_vec, e.dst);
                check({flag_inv, flag_inx} == {e.inv, e.inx}, tg, "flags inv/inx",
                      512'({flag_inv, flag_inx}), 512'({e.inv, e.inx}));
                check(undef_op == e.ud, tg, "undef_op", 512'(undef_op), 512'(e.ud));
                check((cyc - t_start) == int'(e.lat), "R11", "latency",
                      512'(cyc - t_start), 512'(e.lat));
            end
        end
    end

    localparam logic [31:0] F_1P0  = 32'h3F80_0000;
    localparam logic [31:0] F_1P5  = 32'h3FC0_0000;
    localparam logic [31:0] F_2P5  = 32'h4020_0000;
    localparam logic [31:0] F_3P5  = 32'h4060_0000;
    localparam logic [31:0] F_M0P5 = 32'hBF00_0000;
    localparam logic [31:0] F_NAN  = 32'h7FC0_0000;
    localparam logic [31:0] F_INF  = 32'h7F80_0000;
    localparam logic [31:0] F_2E32 = 32'h4F80_0000;
    localparam logic [31:0] F_MAXU = 32'h4F7F_FFFF;
    localparam logic [31:0] F_DEN  = 32'h0000_0001;
    localparam logic [31:0] F_BIG  = 32'h47F1_2000;
    localparam logic [31:0] F_M2P0 = 32'hC000_0000;

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [511:0] tbl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(dst_vec == '0, "R11", "reset dst", dst_vec, '0);
        check({done, undef_op, flag_inv, flag_inx} == 4'b0, "R11", "reset ctl",
              512'({done, undef_op, flag_inv, flag_inx}), '0);

        tbl = {F_M2P0, F_BIG, F_DEN, F_MAXU, F_2E32, F_INF, F_NAN, F_M0P5,
               F_3P5, F_2P5, F_1P5, F_1P0, 32'h0000_0000, 32'h8000_0000,
               32'h3E99_999A, 32'h4B80_0001};

        // R1 R2 R3: full length, every rounding mode
        src_vec = tbl;
        for (int m = 0; m < 4; m++) begin
            set_op(2'd2, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'(m), 2'(3 - m));
            run_op(m == 0 ? "R2" : "R3");
        end
        // R2 rounding: 2.5, 3.5, -0.5 in the low lanes only
        src_vec = '0;
        src_vec[127:0] = {F_M0P5, F_3P5, F_2P5, F_1P5};
        for (int m = 0; m < 4; m++) begin
            set_op(2'd0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'(m), 2'b00);
            run_op("R2");
        end
        // R1 R8: short lengths with junk above
        src_vec = tbl;
        old_dst = {16{32'hDEAD_BEEF}};
        set_op(2'd0, 1'b0, 1'b0, 16'hFFF0, 1'b1, 1'b0, 2'b00, 2'b00);
        run_op("R8");
        set_op(2'd1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'b11, 2'b00);
        run_op("R1");
        // R6 R7: merge and zero masking
        set_op(2'd1, 1'b0, 1'b0, 16'h00A5, 1'b1, 1'b0, 2'b00, 2'b00);
        run_op("R7");
        set_op(2'd2, 1'b0, 1'b0, 16'h5A3C, 1'b1, 1'b1, 2'b00, 2'b00);
        run_op("R6");
        // R9: invalid and inexact lanes masked off only
        src_vec = '0;
        src_vec[31:0] = F_NAN; src_vec[63:32] = F_1P5; src_vec[95:64] = F_1P0;
        set_op(2'd0, 1'b0, 1'b0, 16'h0004, 1'b1, 1'b0, 2'b00, 2'b00);
        run_op("R9");
        // R4: override used at 512 for register source
        src_vec = {16{F_1P5}};
        set_op(2'd2, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 2'b10);
        run_op("R4");
        set_op(2'd1, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, 2'b00, 2'b10);
        run_op("R4");
        // R5: broadcast from memory, global rounding
        src_vec = tbl;
        src_vec[31:0] = F_2P5;
        set_op(2'd2, 1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 2'b11, 2'b10);
        run_op("R5");
        set_op(2'd1, 1'b1, 1'b1, 16'h0F0F, 1'b1, 1'b1, 2'b10, 2'b00);
        run_op("R5");
        // R10: illegal specifier and illegal length
        set_op(2'd2, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'b00, 2'b00);
        spec_field = 4'b0111;
        run_op("R10");
        set_op(2'd3, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'b00, 2'b00);
        run_op("R10");
        // R11: start held while busy is ignored
        begin
            exp_t e;
            src_vec = tbl;
            set_op(2'd2, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'b00, 2'b00);
            model(e);
            q.push_back(e); tq.push_back("R11");
            start = 1'b1; t_start = cyc;
            @(negedge clk);
            spec_field = 4'h0;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            repeat (3) @(negedge clk);
        end
        // pseudo-random requests
        for (int n = 0; n < 40; n++) begin
            for (int j = 0; j < 16; j++) begin
                logic [31:0] rv;
                rv = rnd32();
                src_vec[32*j +: 32] = {rv[31] & rv[30] & rv[29], 8'(8'd110 + (rv[27:22] % 8'd52)), rv[22:0]};
            end
            old_dst = {rnd32(), rnd32(), rnd32(), rnd32(), rnd32(), rnd32(), rnd32(), rnd32(),
                       rnd32(), rnd32(), rnd32(), rnd32(), rnd32(), rnd32(), rnd32(), rnd32()};
            begin
                logic [31:0] c;
                c = rnd32();
                set_op(2'(c[1:0] % 2'd3), c[2], c[3], c[31:16], c[4], c[5], c[7:6], c[9:8]);
                if (c[15:10] == 6'd0) spec_field = 4'hE;
            end
            run_op("R2");
        end
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R11", "all results seen", 512'(q.size()), '0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule